// File: doc/BRIEF.md
# Dot Clock PLL Programming Sequencer

This block turns a requested pixel clock, given in kHz, into a setting word for the dot clock PLL and then drives the PLL control register through the full reprogramming handshake. A fixed table of 59 supported frequencies, from about 24.9 MHz to about 320.2 MHz, is scanned for the entry closest to the request. The low 15 bits of that entry's raw value become the setting word.

If the PLL already reports lock and its register already holds that word, the block finishes without touching the register. Otherwise it runs four steps in order. It writes the new word with reset raised and with the bypass and half-pixel controls lowered. It then waits a settling time of 100 µs, counted in system clock cycles. Next it samples the lock flag until lock is seen, up to a bounded number of samples. Finally it writes the register once more with reset lowered and every other field as it reads back.

The control register sits outside the block. The block reads it through `pll_rd_*` inputs and updates it with one-cycle write strobes. A one-cycle `done` pulse ends every request, and `timeout` comes with that pulse when lock was never seen.

Top module: `dotclk_pll_seq`

## Requirements
- R1: The programmed setting word (`pll_wr_word`, 15 bits) is the table entry whose frequency has the smallest absolute difference from `req_khz`.
- R2: When two entries are equally close, the one earlier in the table (lower frequency) wins. Requests below the lowest entry select the lowest entry, and requests above the highest entry select the highest entry.
- R3: The programming write is a single `pll_wr` cycle with `pll_wr_reset`=1, `pll_wr_bypass`=0 and `pll_wr_halfpix`=0, and it carries the new word.
- R4: If `pll_lock` is 1 and `pll_rd_word` equals the selected word when the search ends, `done` pulses with no write. With lock low, the same word is programmed normally.
- R5: After the programming write the block waits WAIT_CYC = CLK_KHZ*SETTLE_US/1000 cycles with no write before it takes the first lock sample. With lock already high, the release write comes exactly WAIT_CYC+2 cycles after the programming write.
- R6: Polling stops at the first lock sample. If lock first appears D cycles after the programming write (D > WAIT_CYC), the release write follows D+2 cycles after it, with `timeout`=0.
- R7: After POLL_MAX samples with no lock, the release write is still made, WAIT_CYC+POLL_MAX+1 cycles after the programming write, and `timeout`=1 together with `done`.
- R8: The release write has `pll_wr_reset`=0 and copies `pll_rd_word`, `pll_rd_bypass` and `pll_rd_halfpix` unchanged. It occurs in the same cycle as `done`.
- R9: `req_valid` is ignored unless the block is idle: a request during a sequence neither changes the word being programmed nor starts a later sequence.
- R10: `done` is high for exactly one cycle per accepted request, and `timeout` is never high without `done`.
- R11: During and right after reset, `pll_wr`, `done` and `timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_khz | input | 20 | Requested dot clock frequency in kHz |
| pll_lock | input | 1 | PLL lock status flag |
| pll_rd_word | input | 15 | Setting word currently held in the PLL control register |
| pll_rd_bypass | input | 1 | Bypass control currently held in the register |
| pll_rd_halfpix | input | 1 | Half-pixel control currently held in the register |
| pll_wr | output | 1 | One-cycle register write strobe |
| pll_wr_word | output | 15 | Setting word to write |
| pll_wr_reset | output | 1 | PLL reset control to write |
| pll_wr_bypass | output | 1 | Bypass control to write |
| pll_wr_halfpix | output | 1 | Half-pixel control to write |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | High with `done` when lock was never seen |

## Verification
The hardest case to reach is a release write that must keep bypass and half-pixel values differing from those the programming write just forced to zero. The bench modifies its register model in the middle of the settling wait. It also sends a second request during that same window, to show that busy requests are ignored. Polling length is measured with a lock model that raises lock a chosen number of cycles after the reset write. That one knob yields the already-locked, first-lock-late and never-locked timings. Nearest-entry selection is driven with exact hits, out-of-range requests and midpoints that tie exactly between two entries.

// File: rtl/dotclk_pkg.sv
package dotclk_pkg;

    localparam int FREQ_W    = 20;
    localparam int WORD_W    = 15;
    localparam int N_ENTRIES = 59;

    typedef logic [FREQ_W-1:0] freq_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        freq_t       khz;
        logic [15:0] raw;
    } entry_t;

    typedef struct packed {
        logic  wr;
        word_t word;
        logic  reset_on;
        logic  bypass;
        logic  halfpix;
    } pll_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_PROG, ST_WAIT, ST_POLL, ST_RELEASE
    } state_t;

    function automatic freq_t abs_diff(input freq_t a, input freq_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Supported frequencies in ascending order; the order sets tie priority.
    function automatic entry_t entry_at(input int idx);
        entry_t e;
        case (idx)
            0:  e = '{20'd24923,  16'h31AC};
            1:  e = '{20'd25175,  16'h215D};
            2:  e = '{20'd27000,  16'h1087};
            3:  e = '{20'd28322,  16'h216C};
            4:  e = '{20'd28560,  16'h218D};
            5:  e = '{20'd31200,  16'h10C9};
            6:  e = '{20'd31500,  16'h3147};
            7:  e = '{20'd33032,  16'h10A7};
            8:  e = '{20'd35112,  16'h2159};
            9:  e = '{20'd35500,  16'h4249};
            10: e = '{20'd36000,  16'h0057};
            11: e = '{20'd37889,  16'h219A};
            12: e = '{20'd39168,  16'h2158};
            13: e = '{20'd40000,  16'h0045};
            14: e = '{20'd43163,  16'h0089};
            15: e = '{20'd44900,  16'h10E7};
            16: e = '{20'd45720,  16'h2136};
            17: e = '{20'd49500,  16'h3207};
            18: e = '{20'd50000,  16'h2187};
            19: e = '{20'd56250,  16'h4286};
            20: e = '{20'd60065,  16'h10E5};
            21: e = '{20'd65000,  16'h4214};
            22: e = '{20'd68179,  16'h1105};
            23: e = '{20'd74250,  16'h31E4};
            24: e = '{20'd75000,  16'h3183};
            25: e = '{20'd78750,  16'h4284};
            26: e = '{20'd81600,  16'h1104};
            27: e = '{20'd94500,  16'h6363};
            28: e = '{20'd97520,  16'h5303};
            29: e = '{20'd100187, 16'h2183};
            30: e = '{20'd101420, 16'h2122};
            31: e = '{20'd108000, 16'h1081};
            32: e = '{20'd113310, 16'h6201};
            33: e = '{20'd119650, 16'h0041};
            34: e = '{20'd129600, 16'h41A1};
            35: e = '{20'd133500, 16'h2182};
            36: e = '{20'd135000, 16'h41B1};
            37: e = '{20'd144000, 16'h0051};
            38: e = '{20'd148500, 16'h41E1};
            39: e = '{20'd157500, 16'h62D1};
            40: e = '{20'd162000, 16'h31A1};
            41: e = '{20'd169203, 16'h0061};
            42: e = '{20'd172800, 16'h4231};
            43: e = '{20'd175500, 16'h2151};
            44: e = '{20'd189000, 16'h52E1};
            45: e = '{20'd192000, 16'h0071};
            46: e = '{20'd198000, 16'h3201};
            47: e = '{20'd202500, 16'h4291};
            48: e = '{20'd204750, 16'h1101};
            49: e = '{20'd218250, 16'h7481};
            50: e = '{20'd229500, 16'h4170};
            51: e = '{20'd234000, 16'h6210};
            52: e = '{20'd251182, 16'h3140};
            53: e = '{20'd261000, 16'h6250};
            54: e = '{20'd278400, 16'h41C0};
            55: e = '{20'd280640, 16'h5220};
            56: e = '{20'd288000, 16'h0050};
            57: e = '{20'd297000, 16'h41E0};
            58: e = '{20'd320207, 16'h2130};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/dotclk_nearest.sv
// Serial nearest-entry search: one table entry per cycle, strict less-than
// keeps the earliest of equally close entries (R1, R2).
module dotclk_nearest
    import dotclk_pkg::*;
#(
    parameter int N = N_ENTRIES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  freq_t target,
    output logic  found,
    output word_t best_word
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] idx;
    logic          running;
    freq_t         tgt_q;
    freq_t         best_diff;
    freq_t         cur_diff;
    entry_t        cur;

    always_comb begin
        cur      = entry_at(int'(idx));
        cur_diff = abs_diff(cur.khz, tgt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            running   <= 1'b0;
            found     <= 1'b0;
            tgt_q     <= '0;
            best_diff <= '1;
            best_word <= '0;
        end else if (start) begin
            idx       <= '0;
            running   <= 1'b1;
            found     <= 1'b0;
            tgt_q     <= target;
            best_diff <= '1;
        end else begin
            found <= running && (idx == LAST);
            if (running) begin
                if (cur_diff < best_diff) begin
                    best_diff <= cur_diff;
                    best_word <= cur.raw[WORD_W-1:0];
                end
                if (idx == LAST) begin
                    running <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dotclk_timer.sv
// Loadable down counter shared by the settling wait and the poll budget.
module dotclk_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dotclk_seq.sv
// Control sequence: search, skip check, program, settle, poll, release.
module dotclk_seq
    import dotclk_pkg::*;
#(
    parameter int WAIT_CYC = 100,
    parameter int POLL_MAX = 1000,
    parameter int CW       = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          scan_found,
    input  word_t         best_word,
    input  logic          tmr_zero,
    input  logic          pll_lock,
    input  word_t         rd_word,
    input  logic          rd_bypass,
    input  logic          rd_halfpix,
    output logic          scan_start,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_tick,
    output pll_cmd_t      cmd,
    output logic          done,
    output logic          timeout
);
    state_t st, st_nx;
    logic   to_q, to_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            to_q <= 1'b0;
        end else begin
            st   <= st_nx;
            to_q <= to_nx;
        end
    end

    always_comb begin
        st_nx      = st;
        to_nx      = to_q;
        scan_start = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tmr_tick   = 1'b0;
        cmd        = '0;
        done       = 1'b0;
        timeout    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    scan_start = 1'b1;
                    st_nx      = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_found) begin
                    if (pll_lock && (rd_word == best_word)) begin
                        done  = 1'b1;
                        st_nx = ST_IDLE;
                    end else begin
                        st_nx = ST_PROG;
                    end
                end
            end
            ST_PROG: begin
                cmd      = '{wr: 1'b1, word: best_word, reset_on: 1'b1,
                             bypass: 1'b0, halfpix: 1'b0};
                tmr_load = 1'b1;
                tmr_val  = CW'(WAIT_CYC - 1);
                st_nx    = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = CW'(POLL_MAX - 1);
                    st_nx    = ST_POLL;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_POLL: begin
                if (pll_lock) begin
                    to_nx = 1'b0;
                    st_nx = ST_RELEASE;
                end else if (tmr_zero) begin
                    to_nx = 1'b1;
                    st_nx = ST_RELEASE;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_RELEASE: begin
                cmd     = '{wr: 1'b1, word: rd_word, reset_on: 1'b0,
                            bypass: rd_bypass, halfpix: rd_halfpix};
                done    = 1'b1;
                timeout = to_q;
                st_nx   = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dotclk_pll_seq.sv
module dotclk_pll_seq
    import dotclk_pkg::*;
#(
    parameter int CLK_KHZ   = 100000,
    parameter int SETTLE_US = 100,
    parameter int POLL_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic              pll_lock,
    input  logic [WORD_W-1:0] pll_rd_word,
    input  logic              pll_rd_bypass,
    input  logic              pll_rd_halfpix,
    output logic              pll_wr,
    output logic [WORD_W-1:0] pll_wr_word,
    output logic              pll_wr_reset,
    output logic              pll_wr_bypass,
    output logic              pll_wr_halfpix,
    output logic              done,
    output logic              timeout
);
    localparam int WAIT_RAW = (CLK_KHZ * SETTLE_US) / 1000;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int CNT_MAX  = (WAIT_CYC > POLL_MAX) ? WAIT_CYC : POLL_MAX;
    localparam int CW       = $clog2(CNT_MAX + 1);

    logic          scan_start, scan_found;
    word_t         best_word;
    logic          tmr_load, tmr_tick, tmr_zero;
    logic [CW-1:0] tmr_val;
    pll_cmd_t      cmd;

    dotclk_nearest #(.N(N_ENTRIES)) i_nearest (
        .clk       (clk),
        .rst       (rst),
        .start     (scan_start),
        .target    (req_khz),
        .found     (scan_found),
        .best_word (best_word)
    );

    dotclk_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tmr_tick),
        .zero     (tmr_zero)
    );

    dotclk_seq #(.WAIT_CYC(WAIT_CYC), .POLL_MAX(POLL_MAX), .CW(CW)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .scan_found (scan_found),
        .best_word  (best_word),
        .tmr_zero   (tmr_zero),
        .pll_lock   (pll_lock),
        .rd_word    (pll_rd_word),
        .rd_bypass  (pll_rd_bypass),
        .rd_halfpix (pll_rd_halfpix),
        .scan_start (scan_start),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .tmr_tick   (tmr_tick),
        .cmd        (cmd),
        .done       (done),
        .timeout    (timeout)
    );

    assign pll_wr         = cmd.wr;
    assign pll_wr_word    = cmd.word;
    assign pll_wr_reset   = cmd.reset_on;
    assign pll_wr_bypass  = cmd.bypass;
    assign pll_wr_halfpix = cmd.halfpix;

endmodule

// File: rtl/dotclk_pll_seq_chk.sv
module dotclk_pll_seq_chk
    import dotclk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [FREQ_W-1:0] req_khz,
    input logic              pll_lock,
    input logic [WORD_W-1:0] pll_rd_word,
    input logic              pll_rd_bypass,
    input logic              pll_rd_halfpix,
    input logic              pll_wr,
    input logic [WORD_W-1:0] pll_wr_word,
    input logic              pll_wr_reset,
    input logic              pll_wr_bypass,
    input logic              pll_wr_halfpix,
    input logic              done,
    input logic              timeout
);
    assert_prog_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pll_wr && pll_wr_reset) |-> (!pll_wr_bypass && !pll_wr_halfpix));

    assert_settle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (pll_wr && pll_wr_reset) |=> (!pll_wr && !done));

    assert_release_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (pll_wr && !pll_wr_reset) |-> (done && pll_wr_word == pll_rd_word &&
            pll_wr_bypass == pll_rd_bypass && pll_wr_halfpix == pll_rd_halfpix));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done);

    assert_no_prog_at_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !(pll_wr && pll_wr_reset));

endmodule

bind dotclk_pll_seq dotclk_pll_seq_chk i_chk (.*);

// File: tb/test_dotclk_pll_seq.sv
module test_dotclk_pll_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 1000;
    localparam int W          = 100;   // CLK_KHZ*100/1000
    localparam int P          = 1000;
    localparam int NEVER      = 1000000;
    localparam int NV         = 10;

    localparam logic [19:0] VF [NV] = '{20'd25175, 20'd24000, 20'd100000, 20'd25049,
        20'd25050, 20'd400000, 20'd74625, 20'd0, 20'd65000, 20'd148500};
    localparam logic [14:0] VW [NV] = '{15'h215D, 15'h31AC, 15'h2183, 15'h31AC,
        15'h215D, 15'h2130, 15'h31E4, 15'h31AC, 15'h4214, 15'h41E1};
    string vtag [NV] = '{"R1 exact", "R2 below range", "R1 nearest", "R2 tie",
        "R1 near midpoint", "R2 above range", "R2 tie", "R2 zero", "R1 exact", "R1 exact"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_khz = '0;
    logic        pll_lock;
    logic [14:0] reg_word = '0;
    logic        reg_byp = 1'b0, reg_half = 1'b0;
    logic        pll_wr, pll_wr_reset, pll_wr_bypass, pll_wr_halfpix, done, timeout;
    logic [14:0] pll_wr_word;

    int errors = 0, checks = 0;
    int cyc = 0, since = 0, lock_after = NEVER;
    logic poke_req = 1'b0, poke_b = 1'b0, poke_h = 1'b0;

    int n_wr = 0, n_done = 0, n_tmo = 0, n_stray = 0;
    int prog_cyc = 0, rel_cyc = 0;
    logic [14:0] prog_word = '0, rel_word = '0;
    logic prog_byp = 1'b0, prog_half = 1'b0, rel_byp = 1'b0, rel_half = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dotclk_pll_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(100), .POLL_MAX(P)) i_dotclk_pll_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_khz(req_khz),
        .pll_lock(pll_lock), .pll_rd_word(reg_word), .pll_rd_bypass(reg_byp),
        .pll_rd_halfpix(reg_half), .pll_wr(pll_wr), .pll_wr_word(pll_wr_word),
        .pll_wr_reset(pll_wr_reset), .pll_wr_bypass(pll_wr_bypass),
        .pll_wr_halfpix(pll_wr_halfpix), .done(done), .timeout(timeout));

    // PLL register and lock model
    assign pll_lock = (since >= lock_after);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pll_wr && pll_wr_reset) since <= 0;
        else if (since < NEVER) since <= since + 1;
        if (pll_wr) begin
            reg_word <= pll_wr_word;
            reg_byp  <= pll_wr_bypass;
            reg_half <= pll_wr_halfpix;
        end else if (poke_req) begin
            reg_byp  <= poke_b;
            reg_half <= poke_h;
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pll_wr) begin
                n_wr = n_wr + 1;
                if (pll_wr_reset) begin
                    prog_cyc = cyc; prog_word = pll_wr_word;
                    prog_byp = pll_wr_bypass; prog_half = pll_wr_halfpix;
                end else begin
                    rel_cyc = cyc; rel_word = pll_wr_word;
                    rel_byp = pll_wr_bypass; rel_half = pll_wr_halfpix;
                end
            end
            if (done) begin
                n_done = n_done + 1;
                if (timeout) n_tmo = n_tmo + 1;
            end
            if (timeout && !done) n_stray = n_stray + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic poke(input logic b, input logic h);
        @(negedge clk); poke_req = 1'b1; poke_b = b; poke_h = h;
        @(negedge clk); poke_req = 1'b0;
    endtask

    task automatic send(input logic [19:0] f);
        @(negedge clk); req_valid = 1'b1; req_khz = f;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_done(input int base_done);
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            if (n_done > base_done) break;
        end
        repeat (3) @(posedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int bw, bd, bt;
        repeat (3) @(negedge clk);
        chk(pll_wr == 1'b0, "R11 wr in reset", int'(pll_wr), 0);
        chk(done == 1'b0, "R11 done in reset", int'(done), 0);
        chk(timeout == 1'b0, "R11 timeout in reset", int'(timeout), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!pll_wr && !done, "R11 idle after reset", int'(pll_wr | done), 0);

        // Vector table: nearest selection, program fields, settle timing
        lock_after = 0;
        for (int i = 0; i < NV; i++) begin
            poke(1'b1, 1'b1);
            bw = n_wr; bd = n_done; bt = n_tmo;
            send(VF[i]);
            wait_done(bd);
            chk(prog_word == VW[i], vtag[i], int'(prog_word), int'(VW[i]));
            chk(n_wr - bw == 2, "R3 write count", n_wr - bw, 2);
            chk(!prog_byp && !prog_half, "R3 bypass/halfpix cleared",
                int'({prog_byp, prog_half}), 0);
            chk(rel_cyc - prog_cyc == W + 2, "R5 settle then release",
                rel_cyc - prog_cyc, W + 2);
            chk(rel_word == VW[i], "R8 release word", int'(rel_word), int'(VW[i]));
            chk(n_done - bd == 1, "R10 single done", n_done - bd, 1);
            chk(n_tmo == bt, "R7 no timeout when locked", n_tmo - bt, 0);
        end

        // Skip when locked at the same word
        bw = n_wr; bd = n_done;
        send(20'd148500);
        wait_done(bd);
        chk(n_wr == bw, "R4 skip writes", n_wr - bw, 0);
        chk(n_done - bd == 1, "R4 skip done", n_done - bd, 1);

        // Lock appears late: polling stops at first lock
        lock_after = W + 10;
        bw = n_wr; bd = n_done; bt = n_tmo;
        send(20'd65000);
        wait_done(bd);
        chk(rel_cyc - prog_cyc == W + 12, "R6 first lock ends poll",
            rel_cyc - prog_cyc, W + 12);
        chk(n_tmo == bt, "R6 no timeout", n_tmo - bt, 0);

        // Release keeps fields changed mid-sequence; busy request ignored
        lock_after = 0;
        bw = n_wr; bd = n_done;
        send(20'd100000);
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            if (n_wr > bw) break;
        end
        poke(1'b1, 1'b1);
        send(20'd320207);
        wait_done(bd);
        chk(prog_word == 15'h2183, "R9 busy request ignored", int'(prog_word), 'h2183);
        chk(rel_byp && rel_half, "R8 release keeps bypass/halfpix",
            int'({rel_byp, rel_half}), 3);
        chk(rel_word == 15'h2183, "R8 release keeps word", int'(rel_word), 'h2183);
        repeat (200) @(posedge clk);
        chk(n_wr - bw == 2, "R9 no extra sequence", n_wr - bw, 2);
        chk(n_done - bd == 1, "R9 single done", n_done - bd, 1);

        // Same word but no lock: must program, then time out
        lock_after = NEVER;
        bw = n_wr; bd = n_done; bt = n_tmo;
        send(20'd100000);
        wait_done(bd);
        chk(n_wr - bw == 2, "R4 reprogram when unlocked", n_wr - bw, 2);
        chk(n_tmo - bt == 1, "R7 timeout flagged", n_tmo - bt, 1);
        chk(rel_cyc - prog_cyc == W + P + 1, "R7 poll budget",
            rel_cyc - prog_cyc, W + P + 1);
        chk(n_stray == 0, "R10 timeout only with done", n_stray, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule